// File: doc/BRIEF.md
# Interrupt Gate Validator

This block decides whether an interrupt or exception can be taken through a gate descriptor in a protected, segmented machine. For each request it receives the vector number, whether the event came from a software interrupt instruction, the descriptor table limit, the current privilege level and the already-decoded fields of two descriptors. The first is the gate read from the table. The second is the code segment that the gate names. The block does not read memory and does not push anything on a stack. It only produces a verdict.

The verdict has one of two forms. The first is a fault, given as a fault vector and an error code. The second is a go-ahead, given as a path code (same privilege, inner privilege or task switch) together with two flags: whether the gate is a 32-bit gate, and whether the interrupt-enable flag must be cleared. The checks run in a fixed priority order. The first failing check decides the fault, and each check forms its error code in its own way. A wide-table mode covers 16-byte gate entries.

Top module: `intgate_validator`

## Requirements
- R1: A request sampled with `req_valid` high gives exactly one `res_valid` pulse, 1 + IN_REG clock cycles later (1 cycle by default). A cycle with no request gives no pulse. After reset all outputs are 0.
- R2: The last byte of the entry is vector*8+7, or vector*16+15 when `req_wide` is 1. If this exceeds `idt_limit`, the result is a general-protection fault (fault vector 13) with error code vector*8+2 (vector*16+2 when wide). This check has the highest priority.
- R3: The gate is rejected with fault 13 and the R2 error code in any of these cases: `gate_ok` is 0, `gate_is_seg` is 1, or `gate_type` is not one of 5, 6, 7, 14, 15. When wide, only 14 and 15 are legal.
- R4: When `req_sw_int` is 1 and `gate_dpl` < `cur_cpl`, the result is fault 13 with the R2 error code. Hardware events skip this check.
- R5: A gate with `gate_present` = 0 gives a not-present fault (fault vector 11) with the R2 error code. This check applies only after the checks of R3 and R4 have passed.
- R6: A legal, present gate of type 5 gives a go-ahead with path code 3 (task). No target check is applied, and both flags are 0.
- R7: A target selector whose bits above bit 1 are all zero gives fault 13 with error code 0.
- R8: A target that is invalid, is not a segment, is not code, or has DPL > `cur_cpl` gives fault 13. The error code is the selector with bits 1:0 cleared. Otherwise, a target with `tgt_present` = 0 gives fault 11 with that same code.
- R9: A non-conforming target with DPL < `cur_cpl` gives path code 2 (inner). In v8086 mode this path also needs target DPL 0; otherwise the result is fault 13 with the masked selector.
- R10: Any other accepted target gives path code 1 (same), except in v8086 mode, where it gives fault 13 with the masked selector.
- R11: On an interrupt or trap gate go-ahead, `res_gate32` equals 1 for types 14 and 15. `res_clr_if` equals 1 for even types (6, 14) and 0 for odd types (7, 15).
- R12: Every fault result carries path code 0 with both flags at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_vector | input | VEC_W | Interrupt vector number |
| req_sw_int | input | 1 | Event raised by a software interrupt instruction |
| req_wide | input | 1 | 16-byte table entries |
| idt_limit | input | LIMIT_W | Descriptor table limit in bytes |
| cur_cpl | input | 2 | Current privilege level |
| v86_mode | input | 1 | Virtual-8086 mode active |
| gate_ok | input | 1 | Gate descriptor decoded as valid |
| gate_is_seg | input | 1 | Gate descriptor has the segment (non-system) bit set |
| gate_type | input | 4 | Gate type field |
| gate_dpl | input | 2 | Gate descriptor privilege level |
| gate_present | input | 1 | Gate present bit |
| tgt_sel | input | SEL_W | Code-segment selector held in the gate |
| tgt_ok | input | 1 | Target descriptor decoded as valid |
| tgt_is_seg | input | 1 | Target is a code/data segment descriptor |
| tgt_is_code | input | 1 | Target is a code segment |
| tgt_conforming | input | 1 | Target code segment is conforming |
| tgt_dpl | input | 2 | Target descriptor privilege level |
| tgt_present | input | 1 | Target present bit |
| res_valid | output | 1 | One-cycle result strobe |
| res_fault | output | 1 | Result is a fault |
| res_fault_vec | output | 8 | Fault vector (13 or 11) |
| res_err | output | SEL_W | Fault error code |
| res_path | output | 2 | 0 none, 1 same, 2 inner, 3 task |
| res_gate32 | output | 1 | 32-bit gate |
| res_clr_if | output | 1 | Interrupt-enable flag must be cleared |

## Verification
Directed requests walk the check chain one stage at a time. Each is built so that a single check fails while every check before it passes, which shows that each check is in place and that it produces its own error code. Some requests make two checks fail together, for example a missing gate combined with a privilege violation, or a table overrun combined with a null selector. These show that the order is kept. Limit values just at and just past the entry's last byte separate the narrow and wide address arithmetic. Go-ahead requests cover every gate type, privilege relation and v8086 setting, which separates the same, inner and task paths and the two flag values.

// File: rtl/ivg_pkg.sv
package ivg_pkg;

   typedef enum logic [1:0] {
      PATH_NONE  = 2'd0,
      PATH_SAME  = 2'd1,
      PATH_INNER = 2'd2,
      PATH_TASK  = 2'd3
   } path_e;

   typedef enum logic [1:0] {
      FK_NONE = 2'd0,
      FK_GP   = 2'd1,
      FK_NP   = 2'd2
   } fkind_e;

   localparam logic [7:0] FVEC_GP = 8'd13;
   localparam logic [7:0] FVEC_NP = 8'd11;

   localparam logic [3:0] GT_TASK    = 4'd5;
   localparam logic [3:0] GT_INT16   = 4'd6;
   localparam logic [3:0] GT_TRAP16  = 4'd7;
   localparam logic [3:0] GT_INT32   = 4'd14;
   localparam logic [3:0] GT_TRAP32  = 4'd15;

endpackage

// File: rtl/ivg_in_stage.sv
module ivg_in_stage #(
   parameter int W      = 8,
   parameter int IN_REG = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         d_valid,
   input  logic [W-1:0] d_bus,
   output logic         q_valid,
   output logic [W-1:0] q_bus
);

   generate
      if (IN_REG != 0) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_valid <= 1'b0;
               q_bus   <= '0;
            end else begin
               q_valid <= d_valid;
               q_bus   <= d_bus;
            end
         end
      end else begin : g_wire
         assign q_valid = d_valid;
         assign q_bus   = d_bus;
      end
   endgenerate

endmodule

// File: rtl/ivg_gate_chk.sv
module ivg_gate_chk
   import ivg_pkg::*;
#(
   parameter int VEC_W   = 8,
   parameter int LIMIT_W = 16,
   parameter int ERR_W   = 16
) (
   input  logic [VEC_W-1:0]   vector,
   input  logic               sw_int,
   input  logic               wide,
   input  logic [LIMIT_W-1:0] limit,
   input  logic [1:0]         cpl,
   input  logic               g_ok,
   input  logic               g_is_seg,
   input  logic [3:0]         g_type,
   input  logic [1:0]         g_dpl,
   input  logic               g_present,
   output fkind_e             kind,
   output logic [ERR_W-1:0]   err,
   output logic               is_task,
   output logic               is32,
   output logic               clr_if
);

   localparam int CMP_W = ((LIMIT_W > VEC_W + 4) ? LIMIT_W : VEC_W + 4) + 1;

   logic [CMP_W-1:0] last_byte;
   logic             over_limit;
   logic             type_legal;
   logic [ERR_W-1:0] idx_err;

   always_comb begin
      if (wide) begin
         last_byte = (CMP_W'(vector) << 4) + CMP_W'(15);
         idx_err   = (ERR_W'(vector) << 4) + ERR_W'(2);
      end else begin
         last_byte = (CMP_W'(vector) << 3) + CMP_W'(7);
         idx_err   = (ERR_W'(vector) << 3) + ERR_W'(2);
      end
   end

   assign over_limit = last_byte > CMP_W'(limit);

   always_comb begin
      if (wide) begin
         type_legal = (g_type == GT_INT32) || (g_type == GT_TRAP32);
      end else begin
         type_legal = (g_type == GT_TASK)  || (g_type == GT_INT16) ||
                      (g_type == GT_TRAP16) || (g_type == GT_INT32) ||
                      (g_type == GT_TRAP32);
      end
   end

   always_comb begin
      kind = FK_NONE;
      err  = '0;
      if (over_limit) begin
         kind = FK_GP;
         err  = idx_err;
      end else if (!g_ok || g_is_seg || !type_legal) begin
         kind = FK_GP;
         err  = idx_err;
      end else if (sw_int && (g_dpl < cpl)) begin
         kind = FK_GP;
         err  = idx_err;
      end else if (!g_present) begin
         kind = FK_NP;
         err  = idx_err;
      end
   end

   assign is_task = (g_type == GT_TASK);
   assign is32    = !is_task && g_type[3];
   assign clr_if  = !is_task && !g_type[0];

endmodule

// File: rtl/ivg_tgt_chk.sv
module ivg_tgt_chk
   import ivg_pkg::*;
#(
   parameter int SEL_W = 16
) (
   input  logic [SEL_W-1:0] sel,
   input  logic [1:0]       cpl,
   input  logic             v86,
   input  logic             t_ok,
   input  logic             t_is_seg,
   input  logic             t_is_code,
   input  logic             t_conf,
   input  logic [1:0]       t_dpl,
   input  logic             t_present,
   output fkind_e           kind,
   output logic [SEL_W-1:0] err,
   output path_e            path
);

   logic [SEL_W-1:0] sel_idx;
   logic             inner_cand;

   assign sel_idx    = sel & ~SEL_W'(3);
   assign inner_cand = !t_conf && (t_dpl < cpl);

   always_comb begin
      kind = FK_NONE;
      err  = '0;
      path = PATH_NONE;
      if (sel_idx == '0) begin
         kind = FK_GP;
      end else if (!t_ok || !t_is_seg || !t_is_code || (t_dpl > cpl)) begin
         kind = FK_GP;
         err  = sel_idx;
      end else if (!t_present) begin
         kind = FK_NP;
         err  = sel_idx;
      end else if (inner_cand) begin
         if (v86 && (t_dpl != 2'd0)) begin
            kind = FK_GP;
            err  = sel_idx;
         end else begin
            path = PATH_INNER;
         end
      end else if (v86) begin
         kind = FK_GP;
         err  = sel_idx;
      end else begin
         path = PATH_SAME;
      end
   end

endmodule

// File: rtl/ivg_result_reg.sv
module ivg_result_reg
   import ivg_pkg::*;
#(
   parameter int ERR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  fkind_e           g_kind,
   input  logic [ERR_W-1:0] g_err,
   input  logic             g_task,
   input  logic             g_is32,
   input  logic             g_clr_if,
   input  fkind_e           t_kind,
   input  logic [ERR_W-1:0] t_err,
   input  path_e            t_path,
   output logic             res_valid,
   output logic             res_fault,
   output logic [7:0]       res_fault_vec,
   output logic [ERR_W-1:0] res_err,
   output logic [1:0]       res_path,
   output logic             res_gate32,
   output logic             res_clr_if
);

   fkind_e           sel_kind;
   logic [ERR_W-1:0] sel_err;
   path_e            sel_path;

   always_comb begin
      sel_kind = FK_NONE;
      sel_err  = '0;
      sel_path = PATH_NONE;
      if (g_kind != FK_NONE) begin
         sel_kind = g_kind;
         sel_err  = g_err;
      end else if (g_task) begin
         sel_path = PATH_TASK;
      end else if (t_kind != FK_NONE) begin
         sel_kind = t_kind;
         sel_err  = t_err;
      end else begin
         sel_path = t_path;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid     <= 1'b0;
         res_fault     <= 1'b0;
         res_fault_vec <= '0;
         res_err       <= '0;
         res_path      <= '0;
         res_gate32    <= 1'b0;
         res_clr_if    <= 1'b0;
      end else begin
         res_valid     <= in_valid;
         res_fault     <= in_valid && (sel_kind != FK_NONE);
         res_fault_vec <= !in_valid ? 8'd0 :
                          (sel_kind == FK_GP) ? FVEC_GP :
                          (sel_kind == FK_NP) ? FVEC_NP : 8'd0;
         res_err       <= in_valid ? sel_err : '0;
         res_path      <= in_valid ? sel_path : PATH_NONE;
         res_gate32    <= in_valid && (sel_kind == FK_NONE) && g_is32;
         res_clr_if    <= in_valid && (sel_kind == FK_NONE) && g_clr_if;
      end
   end

   // R1
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !res_valid);

   // R2
   gate_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (g_kind != FK_NONE)) |=> (res_fault && (res_err == $past(g_err))));

   // R6
   task_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (g_kind == FK_NONE) && g_task) |=>
         (!res_fault && (res_path == PATH_TASK)));

   // R12
   fault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_fault) |-> ((res_path == PATH_NONE) && !res_gate32 && !res_clr_if));

   // R5
   fault_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_fault |-> (res_valid && ((res_fault_vec == FVEC_GP) || (res_fault_vec == FVEC_NP))));

endmodule

// File: rtl/intgate_validator.sv
module intgate_validator
   import ivg_pkg::*;
#(
   parameter int VEC_W   = 8,
   parameter int LIMIT_W = 16,
   parameter int SEL_W   = 16,
   parameter int IN_REG  = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [VEC_W-1:0]   req_vector,
   input  logic               req_sw_int,
   input  logic               req_wide,
   input  logic [LIMIT_W-1:0] idt_limit,
   input  logic [1:0]         cur_cpl,
   input  logic               v86_mode,
   input  logic               gate_ok,
   input  logic               gate_is_seg,
   input  logic [3:0]         gate_type,
   input  logic [1:0]         gate_dpl,
   input  logic               gate_present,
   input  logic [SEL_W-1:0]   tgt_sel,
   input  logic               tgt_ok,
   input  logic               tgt_is_seg,
   input  logic               tgt_is_code,
   input  logic               tgt_conforming,
   input  logic [1:0]         tgt_dpl,
   input  logic               tgt_present,
   output logic               res_valid,
   output logic               res_fault,
   output logic [7:0]         res_fault_vec,
   output logic [SEL_W-1:0]   res_err,
   output logic [1:0]         res_path,
   output logic               res_gate32,
   output logic               res_clr_if
);

   localparam int REQ_W = VEC_W + LIMIT_W + SEL_W + 22;

   generate
      if (SEL_W < VEC_W + 4) begin : g_bad_sel
         $error("SEL_W too narrow for a wide-table error code");
      end
      if ((IN_REG != 0) && (IN_REG != 1)) begin : g_bad_inreg
         $error("IN_REG must be 0 or 1");
      end
      if (VEC_W < 1 || LIMIT_W < 4) begin : g_bad_width
         $error("VEC_W or LIMIT_W out of range");
      end
   endgenerate

   logic [REQ_W-1:0] req_bus, stg_bus;
   logic             stg_valid;

   assign req_bus = {req_vector, req_sw_int, req_wide, idt_limit, cur_cpl, v86_mode,
                     gate_ok, gate_is_seg, gate_type, gate_dpl, gate_present,
                     tgt_sel, tgt_ok, tgt_is_seg, tgt_is_code, tgt_conforming,
                     tgt_dpl, tgt_present};

   ivg_in_stage #(.W(REQ_W), .IN_REG(IN_REG)) u_in (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_valid (req_valid),
      .d_bus   (req_bus),
      .q_valid (stg_valid),
      .q_bus   (stg_bus)
   );

   logic [VEC_W-1:0]   s_vector;
   logic               s_sw_int, s_wide, s_v86;
   logic [LIMIT_W-1:0] s_limit;
   logic [1:0]         s_cpl, s_gdpl, s_tdpl;
   logic               s_gok, s_gseg, s_gpres;
   logic [3:0]         s_gtype;
   logic [SEL_W-1:0]   s_sel;
   logic               s_tok, s_tseg, s_tcode, s_tconf, s_tpres;

   assign {s_vector, s_sw_int, s_wide, s_limit, s_cpl, s_v86,
           s_gok, s_gseg, s_gtype, s_gdpl, s_gpres,
           s_sel, s_tok, s_tseg, s_tcode, s_tconf, s_tdpl, s_tpres} = stg_bus;

   fkind_e           g_kind, t_kind;
   logic [SEL_W-1:0] g_err, t_err;
   logic             g_task, g_is32, g_clr_if;
   path_e            t_path;

   ivg_gate_chk #(.VEC_W(VEC_W), .LIMIT_W(LIMIT_W), .ERR_W(SEL_W)) u_gate (
      .vector    (s_vector),
      .sw_int    (s_sw_int),
      .wide      (s_wide),
      .limit     (s_limit),
      .cpl       (s_cpl),
      .g_ok      (s_gok),
      .g_is_seg  (s_gseg),
      .g_type    (s_gtype),
      .g_dpl     (s_gdpl),
      .g_present (s_gpres),
      .kind      (g_kind),
      .err       (g_err),
      .is_task   (g_task),
      .is32      (g_is32),
      .clr_if    (g_clr_if)
   );

   ivg_tgt_chk #(.SEL_W(SEL_W)) u_tgt (
      .sel       (s_sel),
      .cpl       (s_cpl),
      .v86       (s_v86),
      .t_ok      (s_tok),
      .t_is_seg  (s_tseg),
      .t_is_code (s_tcode),
      .t_conf    (s_tconf),
      .t_dpl     (s_tdpl),
      .t_present (s_tpres),
      .kind      (t_kind),
      .err       (t_err),
      .path      (t_path)
   );

   // R9
   v86_inner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stg_valid && s_v86 && (t_path == PATH_INNER)) |-> (s_tdpl == 2'd0));

   // R10
   v86_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stg_valid && s_v86) |-> (t_path != PATH_SAME));

   ivg_result_reg #(.ERR_W(SEL_W)) u_res (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_valid      (stg_valid),
      .g_kind        (g_kind),
      .g_err         (g_err),
      .g_task        (g_task),
      .g_is32        (g_is32),
      .g_clr_if      (g_clr_if),
      .t_kind        (t_kind),
      .t_err         (t_err),
      .t_path        (t_path),
      .res_valid     (res_valid),
      .res_fault     (res_fault),
      .res_fault_vec (res_fault_vec),
      .res_err       (res_err),
      .res_path      (res_path),
      .res_gate32    (res_gate32),
      .res_clr_if    (res_clr_if)
   );

endmodule

// File: tb/tb_intgate_validator.sv
module tb_intgate_validator;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_vector = '0;
   logic        req_sw_int = 1'b0;
   logic        req_wide = 1'b0;
   logic [15:0] idt_limit = '0;
   logic [1:0]  cur_cpl = '0;
   logic        v86_mode = 1'b0;
   logic        gate_ok = 1'b0;
   logic        gate_is_seg = 1'b0;
   logic [3:0]  gate_type = '0;
   logic [1:0]  gate_dpl = '0;
   logic        gate_present = 1'b0;
   logic [15:0] tgt_sel = '0;
   logic        tgt_ok = 1'b0;
   logic        tgt_is_seg = 1'b0;
   logic        tgt_is_code = 1'b0;
   logic        tgt_conforming = 1'b0;
   logic [1:0]  tgt_dpl = '0;
   logic        tgt_present = 1'b0;
   logic        res_valid, res_fault, res_gate32, res_clr_if;
   logic [7:0]  res_fault_vec;
   logic [15:0] res_err;
   logic [1:0]  res_path;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   intgate_validator dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
      .req_sw_int(req_sw_int), .req_wide(req_wide), .idt_limit(idt_limit),
      .cur_cpl(cur_cpl), .v86_mode(v86_mode), .gate_ok(gate_ok),
      .gate_is_seg(gate_is_seg), .gate_type(gate_type), .gate_dpl(gate_dpl),
      .gate_present(gate_present), .tgt_sel(tgt_sel), .tgt_ok(tgt_ok),
      .tgt_is_seg(tgt_is_seg), .tgt_is_code(tgt_is_code),
      .tgt_conforming(tgt_conforming), .tgt_dpl(tgt_dpl), .tgt_present(tgt_present),
      .res_valid(res_valid), .res_fault(res_fault), .res_fault_vec(res_fault_vec),
      .res_err(res_err), .res_path(res_path), .res_gate32(res_gate32),
      .res_clr_if(res_clr_if)
   );

   task automatic chk(input string tag, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic base();
      req_vector = 8'h10; req_sw_int = 1'b0; req_wide = 1'b0; idt_limit = 16'h07FF;
      cur_cpl = 2'd0; v86_mode = 1'b0;
      gate_ok = 1'b1; gate_is_seg = 1'b0; gate_type = 4'd14; gate_dpl = 2'd3;
      gate_present = 1'b1;
      tgt_sel = 16'h002B; tgt_ok = 1'b1; tgt_is_seg = 1'b1; tgt_is_code = 1'b1;
      tgt_conforming = 1'b0; tgt_dpl = 2'd0; tgt_present = 1'b1;
   endtask

   // Fires one request; result registered at the following edge, sampled at negedge.
   task automatic fire(input string tag, input bit ef, input int evec, input int eerr,
                       input int epath, input bit eg32, input bit eclr);
      @(negedge clk);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk({tag, " R1 valid"}, res_valid, 1);
      chk({tag, " fault"}, res_fault, ef);
      if (ef) begin
         chk({tag, " fault vector"}, res_fault_vec, evec);
         chk({tag, " error code"}, res_err, eerr);
         chk({tag, " R12 path"}, res_path, 0);
      end else begin
         chk({tag, " path"}, res_path, epath);
         chk({tag, " R11 gate32"}, res_gate32, eg32);
         chk({tag, " R11 clr_if"}, res_clr_if, eclr);
      end
      @(negedge clk);
      chk({tag, " R1 pulse end"}, res_valid, 0);
   endtask

   task automatic t_reset();
      chk("R1 reset valid", res_valid, 0);
      chk("R1 reset fault", res_fault, 0);
      chk("R1 reset err", res_err, 0);
      chk("R1 reset path", res_path, 0);
   endtask

   task automatic t_limit();
      base(); req_vector = 8'h20; idt_limit = 16'h00FF;
      fire("R2 narrow over", 1, 13, 16'h0102, 0, 0, 0);
      base(); req_vector = 8'h1F; idt_limit = 16'h00FF;
      fire("R2 narrow edge", 0, 0, 0, 1, 1, 1);
      base(); req_wide = 1'b1; req_vector = 8'h10; idt_limit = 16'h00FF;
      fire("R2 wide over", 1, 13, 16'h0102, 0, 0, 0);
      base(); req_wide = 1'b1; req_vector = 8'h0F; idt_limit = 16'h00FF;
      fire("R2 wide edge", 0, 0, 0, 1, 1, 1);
      base(); req_vector = 8'h40; idt_limit = 16'h01FF; tgt_sel = 16'h0003;
      fire("R2 over beats R7", 1, 13, 16'h0202, 0, 0, 0);
   endtask

   task automatic t_type();
      base(); req_vector = 8'd3; gate_type = 4'hC;
      fire("R3 bad type", 1, 13, 16'h001A, 0, 0, 0);
      base(); req_vector = 8'd3; req_wide = 1'b1; gate_type = 4'd6;
      fire("R3 wide narrow type", 1, 13, 16'h0032, 0, 0, 0);
      base(); req_vector = 8'd4; gate_is_seg = 1'b1;
      fire("R3 non-system", 1, 13, 16'h0022, 0, 0, 0);
      base(); req_vector = 8'd4; gate_ok = 1'b0;
      fire("R3 invalid gate", 1, 13, 16'h0022, 0, 0, 0);
   endtask

   task automatic t_swdpl();
      base(); req_vector = 8'h21; cur_cpl = 2'd3; gate_dpl = 2'd2; req_sw_int = 1'b1;
      fire("R4 sw dpl", 1, 13, 16'h010A, 0, 0, 0);
      base(); req_vector = 8'h21; cur_cpl = 2'd3; gate_dpl = 2'd2;
      fire("R4 hw skips", 0, 0, 0, 2, 1, 1);
   endtask

   task automatic t_present();
      base(); req_vector = 8'h21; cur_cpl = 2'd3; gate_dpl = 2'd2; req_sw_int = 1'b1;
      gate_present = 1'b0;
      fire("R5 dpl before np", 1, 13, 16'h010A, 0, 0, 0);
      base(); req_vector = 8'h21; gate_present = 1'b0;
      fire("R5 gate np", 1, 11, 16'h010A, 0, 0, 0);
   endtask

   task automatic t_task();
      base(); gate_type = 4'd5; tgt_sel = 16'h0000; tgt_ok = 1'b0;
      fire("R6 task", 0, 0, 0, 3, 0, 0);
   endtask

   task automatic t_target();
      base(); req_vector = 8'd5; tgt_sel = 16'h0003;
      fire("R7 null sel", 1, 13, 0, 0, 0, 0);
      base(); tgt_is_code = 1'b0;
      fire("R8 data seg", 1, 13, 16'h0028, 0, 0, 0);
      base(); tgt_dpl = 2'd3;
      fire("R8 dpl above cpl", 1, 13, 16'h0028, 0, 0, 0);
      base(); tgt_present = 1'b0;
      fire("R8 target np", 1, 11, 16'h0028, 0, 0, 0);
   endtask

   task automatic t_inner();
      base(); cur_cpl = 2'd3; gate_type = 4'd15;
      fire("R9 inner trap32", 0, 0, 0, 2, 1, 0);
      base(); cur_cpl = 2'd3; v86_mode = 1'b1; tgt_dpl = 2'd1;
      fire("R9 v86 dpl1", 1, 13, 16'h0028, 0, 0, 0);
      base(); cur_cpl = 2'd3; v86_mode = 1'b1;
      fire("R9 v86 dpl0", 0, 0, 0, 2, 1, 1);
   endtask

   task automatic t_same();
      base(); cur_cpl = 2'd3; tgt_conforming = 1'b1; tgt_dpl = 2'd1; gate_type = 4'd7;
      fire("R10 conforming", 0, 0, 0, 1, 0, 0);
      base(); cur_cpl = 2'd2; tgt_dpl = 2'd2; gate_type = 4'd6;
      fire("R10 equal dpl", 0, 0, 0, 1, 0, 1);
      base(); cur_cpl = 2'd3; tgt_conforming = 1'b1; v86_mode = 1'b1;
      fire("R10 v86 conforming", 1, 13, 16'h0028, 0, 0, 0);
   endtask

   task automatic t_back2back();
      base();
      @(negedge clk);
      req_valid = 1'b1;
      @(negedge clk);
      chk("R1 b2b first", res_valid, 1);
      chk("R1 b2b first path", res_path, 1);
      tgt_present = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R1 b2b second", res_valid, 1);
      chk("R8 b2b second vec", res_fault_vec, 11);
      @(negedge clk);
      chk("R1 b2b idle", res_valid, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: got hang expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      base();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_limit();
      t_type();
      t_swdpl();
      t_present();
      t_task();
      t_target();
      t_inner();
      t_same();
      t_back2back();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule